// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a bank of 32 asynchronous input lines and converts the edges on them into interrupt requests. For each line, software chooses whether a rising edge, a falling edge or both count. An accepted rising edge is recorded in one pending register and an accepted falling edge in a second. Software acknowledges a line by writing a one to its bit in the matching pending register. A software-trigger register lets a driver raise a line's pending state without any edge on the input.

Each line drives its own interrupt output. That output is high while the line is unmasked and either of its pending bits is set. A separate event mask turns each accepted edge into a single-cycle pulse on a per-line event output. The event output does not depend on the pending registers.

Software reaches the block through a plain register port made of address, write strobe, write data and read data. Read data is registered and appears one clock after the address is presented.

Top module: `edge_irq_ctrl`

## Requirements
- R1: While `rst` is high, and after it falls, every register reads 0, and `irq_out` and `evt_out` are 0 until an edge or a write changes state.
- R2: Bit n of every register belongs to input line n. An edge on a line is accepted only if it is selected. Rising edges are selected by the rising-select register at offset 0x00 and falling edges by the falling-select register at offset 0x04. A line with both bits set accepts both edges.
- R3: Each input passes two synchronising flops before edge detection. An accepted rising edge sets the line's bit in the rising-pending register (0x0C). An accepted falling edge sets its bit in the falling-pending register (0x10).
- R4: Writing a 1 to a bit of either pending register clears that bit. Bits written with 0 keep their value.
- R5: If an accepted edge and a clearing write hit the same pending bit in the same clock, the bit ends set.
- R6: Writing a 1 to bit n of the software-trigger register (0x08) sets bit n of the rising-pending register. The software-trigger register always reads 0.
- R7: `irq_out[n]` is a registered copy of interrupt-mask bit n (0x80) ANDed with the OR of both pending bits of line n. It lags the registers by one clock.
- R8: `evt_out[n]` is high for exactly one clock for each accepted edge on line n while event-mask bit n (0x84) is set. With that bit clear it stays low.
- R9: Reads from any other offset return 0. Writes to any other offset change no register.
- R10: A write to a select or mask register stores the full data word. The value is returned when the same offset is read, one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset applied one clock earlier |
| ext_in | input | 32 | Asynchronous external lines |
| irq_out | output | 32 | Per-line masked interrupt request |
| evt_out | output | 32 | Per-line single-clock event pulse |

## Verification
The assertions assume that pending bits can fall only in a clock with a write strobe. They also assume that reset leaves the address port at a defined value, so the first read-back check after reset starts from a known offset.

The stimulus meets both conditions. It holds `bus_we` low except for single-clock writes, drives the address from time zero, and changes `ext_in` only on falling clock edges. It holds each input level for several clocks so every edge settles through the synchroniser. The one deliberate exception is the collision case, where a clearing write is placed in the exact clock in which a detected edge reaches the pending register.

// File: rtl/eic_pkg.sv
package eic_pkg;

  localparam int unsigned EIC_ADDR_W = 8;

  typedef logic [EIC_ADDR_W-1:0] eic_off_t;

  // Byte offsets of the register slots
  localparam eic_off_t OFF_RISE_SEL  = 8'h00;
  localparam eic_off_t OFF_FALL_SEL  = 8'h04;
  localparam eic_off_t OFF_SW_TRIG   = 8'h08;
  localparam eic_off_t OFF_RISE_PEND = 8'h0C;
  localparam eic_off_t OFF_FALL_PEND = 8'h10;
  localparam eic_off_t OFF_IRQ_MASK  = 8'h80;
  localparam eic_off_t OFF_EVT_MASK  = 8'h84;

  typedef enum logic [2:0] {
    SLOT_NONE,
    SLOT_RSEL,
    SLOT_FSEL,
    SLOT_SWTRIG,
    SLOT_RPEND,
    SLOT_FPEND,
    SLOT_IMASK,
    SLOT_EMASK
  } eic_slot_e;

  function automatic eic_slot_e eic_decode(input eic_off_t off);
    eic_slot_e s;
    case (off)
      OFF_RISE_SEL:  s = SLOT_RSEL;
      OFF_FALL_SEL:  s = SLOT_FSEL;
      OFF_SW_TRIG:   s = SLOT_SWTRIG;
      OFF_RISE_PEND: s = SLOT_RPEND;
      OFF_FALL_PEND: s = SLOT_FPEND;
      OFF_IRQ_MASK:  s = SLOT_IMASK;
      OFF_EVT_MASK:  s = SLOT_EMASK;
      default:       s = SLOT_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/eic_sync_edge.sv
module eic_sync_edge #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] din,
  output logic [N_LINES-1:0] rise,
  output logic [N_LINES-1:0] fall
);

  localparam int unsigned LAST = STAGES - 1;

  logic [N_LINES-1:0] stg [STAGES];
  logic [N_LINES-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg[LAST];
  end

  assign rise = stg[LAST] & ~prev_q;
  assign fall = ~stg[LAST] & prev_q;

endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  eic_off_t           addr,
  input  logic               we,
  input  logic [N_LINES-1:0] wdata,
  input  logic [N_LINES-1:0] rise_hit,
  input  logic [N_LINES-1:0] fall_hit,
  output logic [N_LINES-1:0] rsel,
  output logic [N_LINES-1:0] fsel,
  output logic [N_LINES-1:0] imask,
  output logic [N_LINES-1:0] emask,
  output logic [N_LINES-1:0] rpend,
  output logic [N_LINES-1:0] fpend,
  output logic [N_LINES-1:0] rdata
);

  eic_slot_e          slot;
  logic [N_LINES-1:0] clr_r, clr_f, sw_set;
  logic [N_LINES-1:0] rpend_d, fpend_d, rd_mux;

  assign slot = eic_decode(addr);

  always_comb begin
    clr_r  = (we && slot == SLOT_RPEND)  ? wdata : '0;
    clr_f  = (we && slot == SLOT_FPEND)  ? wdata : '0;
    sw_set = (we && slot == SLOT_SWTRIG) ? wdata : '0;
    // new edges and software sets override a same-cycle clear
    rpend_d = (rpend & ~clr_r) | rise_hit | sw_set;
    fpend_d = (fpend & ~clr_f) | fall_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel  <= '0;
      fsel  <= '0;
      imask <= '0;
      emask <= '0;
      rpend <= '0;
      fpend <= '0;
    end else begin
      rpend <= rpend_d;
      fpend <= fpend_d;
      if (we) begin
        case (slot)
          SLOT_RSEL:  rsel  <= wdata;
          SLOT_FSEL:  fsel  <= wdata;
          SLOT_IMASK: imask <= wdata;
          SLOT_EMASK: emask <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (slot)
      SLOT_RSEL:  rd_mux = rsel;
      SLOT_FSEL:  rd_mux = fsel;
      SLOT_RPEND: rd_mux = rpend;
      SLOT_FPEND: rd_mux = fpend;
      SLOT_IMASK: rd_mux = imask;
      SLOT_EMASK: rd_mux = emask;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

endmodule

// File: rtl/eic_out_stage.sv
module eic_out_stage #(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] imask,
  input  logic [N_LINES-1:0] emask,
  input  logic [N_LINES-1:0] rpend,
  input  logic [N_LINES-1:0] fpend,
  input  logic [N_LINES-1:0] rise_hit,
  input  logic [N_LINES-1:0] fall_hit,
  output logic [N_LINES-1:0] irq,
  output logic [N_LINES-1:0] evt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= '0;
      evt <= '0;
    end else begin
      irq <= imask & (rpend | fpend);
      evt <= emask & (rise_hit | fall_hit);
    end
  end

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [EIC_ADDR_W-1:0] bus_addr,
  input  logic                  bus_we,
  input  logic [NUM_LINES-1:0]  bus_wdata,
  output logic [NUM_LINES-1:0]  bus_rdata,
  input  logic [NUM_LINES-1:0]  ext_in,
  output logic [NUM_LINES-1:0]  irq_out,
  output logic [NUM_LINES-1:0]  evt_out
);

  logic [NUM_LINES-1:0] rise_w, fall_w, rise_hit, fall_hit;
  logic [NUM_LINES-1:0] rsel_w, fsel_w, imask_w, emask_w, rpend_w, fpend_w;

  eic_sync_edge #(.N_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (ext_in),
    .rise (rise_w),
    .fall (fall_w)
  );

  assign rise_hit = rise_w & rsel_w;
  assign fall_hit = fall_w & fsel_w;

  eic_regs #(.N_LINES(NUM_LINES)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .rise_hit (rise_hit),
    .fall_hit (fall_hit),
    .rsel     (rsel_w),
    .fsel     (fsel_w),
    .imask    (imask_w),
    .emask    (emask_w),
    .rpend    (rpend_w),
    .fpend    (fpend_w),
    .rdata    (bus_rdata)
  );

  eic_out_stage #(.N_LINES(NUM_LINES)) out_i (
    .clk      (clk),
    .rst      (rst),
    .imask    (imask_w),
    .emask    (emask_w),
    .rpend    (rpend_w),
    .fpend    (fpend_w),
    .rise_hit (rise_hit),
    .fall_hit (fall_hit),
    .irq      (irq_out),
    .evt      (evt_out)
  );

endmodule

// File: rtl/eic_chk.sv
module eic_chk
  import eic_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_we,
  input eic_off_t        bus_addr,
  input logic [N-1:0]    bus_rdata,
  input logic [N-1:0]    imask,
  input logic [N-1:0]    emask,
  input logic [N-1:0]    rpend,
  input logic [N-1:0]    fpend,
  input logic [N-1:0]    irq_out,
  input logic [N-1:0]    evt_out
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && evt_out == '0));

  // R7
  masked_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_out & ~$past(imask)) == '0);

  // R8
  masked_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_out & ~$past(emask)) == '0);

  // R4
  rpend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> ((rpend & $past(rpend)) == $past(rpend)));

  // R4
  fpend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> ((fpend & $past(fpend)) == $past(fpend)));

  // R6
  swtrig_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFF_SW_TRIG) |=> (bus_rdata == '0));

endmodule

bind edge_irq_ctrl eic_chk #(.N(NUM_LINES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .imask     (imask_w),
  .emask     (emask_w),
  .rpend     (rpend_w),
  .fpend     (fpend_w),
  .irq_out   (irq_out),
  .evt_out   (evt_out)
);

// File: tb/edge_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module edge_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ext_in = '0;
  logic [31:0] irq_out;
  logic [31:0] evt_out;

  int n_chk  = 0;
  int n_fail = 0;
  int ev0 = 0;
  int ev1 = 0;

  localparam logic [7:0] A_RSEL = 8'h00, A_FSEL = 8'h04, A_SW = 8'h08,
                         A_RP = 8'h0C, A_FP = 8'h10, A_IM = 8'h80, A_EM = 8'h84;

  always #10 clk = ~clk;

  edge_irq_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_in    (ext_in),
    .irq_out   (irq_out),
    .evt_out   (evt_out)
  );

  typedef struct packed {
    logic [31:0] rsel;
    logic [31:0] fsel;
    logic [31:0] lvl_a;
    logic [31:0] lvl_b;
    logic [31:0] exp_rp;
    logic [31:0] exp_fp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_0000},
    '{32'h0F0F_0F0F, 32'h00FF_00FF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0000_0000},
    '{32'h0F0F_0F0F, 32'h00FF_00FF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h00FF_00FF},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 32'hA5A5_A5A5},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000}
  };

  always @(negedge clk) begin
    if (!rst) begin
      if (evt_out[0]) ev0++;
      if (evt_out[1]) ev1++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq_out", irq_out, 32'h0);
    check("R1 evt_out", evt_out, 32'h0);
    rd(A_RSEL, v); check("R1 rsel", v, 32'h0);
    rd(A_FSEL, v); check("R1 fsel", v, 32'h0);
    rd(A_RP, v);   check("R1 rpend", v, 32'h0);
    rd(A_FP, v);   check("R1 fpend", v, 32'h0);
    rd(A_IM, v);   check("R1 imask", v, 32'h0);
    rd(A_EM, v);   check("R1 emask", v, 32'h0);

    // R2 / R3: trigger selection vectors
    for (int i = 0; i < 6; i++) begin
      wr(A_RSEL, VECS[i].rsel);
      wr(A_FSEL, VECS[i].fsel);
      ext_in = VECS[i].lvl_a;
      settle();
      wr(A_RP, 32'hFFFF_FFFF);
      wr(A_FP, 32'hFFFF_FFFF);
      ext_in = VECS[i].lvl_b;
      settle();
      rd(A_RP, v); check("R2 R3 rising pending", v, VECS[i].exp_rp);
      rd(A_FP, v); check("R2 R3 falling pending", v, VECS[i].exp_fp);
    end

    // R10: readback of select register
    wr(A_RSEL, 32'h1234_5678);
    rd(A_RSEL, v); check("R10 readback", v, 32'h1234_5678);

    // R4: selective clear
    wr(A_RSEL, 32'hFFFF_FFFF);
    wr(A_FSEL, 32'hFFFF_FFFF);
    ext_in = 32'hFF00_FF00;   // from 0000FFFF
    settle();
    rd(A_RP, v); check("R3 both edges rise", v, 32'hFF00_0000);
    rd(A_FP, v); check("R3 both edges fall", v, 32'h0000_00FF);
    wr(A_RP, 32'h0F00_0000);
    rd(A_RP, v); check("R4 clear ones only", v, 32'hF000_0000);
    rd(A_FP, v); check("R4 other register untouched", v, 32'h0000_00FF);

    // R7: masked interrupt output
    wr(A_IM, 32'h1000_00F0);
    settle();
    check("R7 irq masked", irq_out, 32'h1000_00F0);
    wr(A_RP, 32'hFFFF_FFFF);
    wr(A_FP, 32'hFFFF_FFFF);
    settle();
    check("R7 irq after clear", irq_out, 32'h0);
    wr(A_IM, 32'h0);

    // R6: software trigger
    wr(A_RSEL, 32'h0);
    wr(A_FSEL, 32'h0);
    ext_in = 32'h0;
    settle();
    wr(A_SW, 32'h8000_0001);
    rd(A_RP, v); check("R6 sw sets rising pending", v, 32'h8000_0001);
    rd(A_FP, v); check("R6 falling pending untouched", v, 32'h0);
    rd(A_SW, v); check("R6 sw reads zero", v, 32'h0);
    wr(A_RP, 32'hFFFF_FFFF);

    // R5: edge and clear in the same clock
    wr(A_RSEL, 32'h0000_0008);
    wr(A_SW, 32'h0000_0008);
    @(negedge clk);
    ext_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = A_RP; bus_wdata = 32'h0000_0008; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    settle();
    rd(A_RP, v); check("R5 edge beats clear", v, 32'h0000_0008);
    wr(A_RP, 32'h0000_0008);
    rd(A_RP, v); check("R5 plain clear", v, 32'h0);

    // R8: event pulses
    wr(A_RSEL, 32'h3);
    wr(A_FSEL, 32'h3);
    wr(A_EM, 32'h1);
    settle();
    ev0 = 0; ev1 = 0;
    ext_in[1:0] = 2'b11;
    settle();
    ext_in[1:0] = 2'b00;
    settle();
    check("R8 event pulses line0", ev0, 2);
    check("R8 no event line1 masked", ev1, 0);

    // R9: unmapped offsets
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h8C, 32'hFFFF_FFFF);
    rd(8'h40, v); check("R9 unmapped read", v, 32'h0);
    rd(A_EM, v);  check("R9 emask unchanged", v, 32'h1);
    rd(A_RSEL, v); check("R9 rsel unchanged", v, 32'h3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule